// File: doc/BRIEF.md
# Receive Copy and Buffer Status Controller

This block moves a validated receive frame out of a hidden staging buffer and into one message buffer. It also holds the 4-bit status code of every message buffer. An upstream matcher raises a validation strobe at the next-to-last end-of-frame bit, together with the index of the buffer it chose. The block then runs a fixed-length copy sequence. That sequence drives the identifier, the control word and each data byte onto a buffer-memory write port, one word per cycle. While the copy runs, the block sets bit 0 of the target buffer's status as an in-progress flag. When the copy ends, it loads the next status code: full after ready, overrun after full.

The CPU writes message buffers through the same block. Data writes pass to a separate memory port unless they target the buffer being filled, in which case they are dropped. Status writes are always accepted. A status written during a copy is translated when the copy completes, so a CPU acknowledge that races with a new frame is never lost. A one-cycle completion pulse carries the buffer index to interrupt logic. A second validation strobe that arrives mid-copy waits in a single pending slot.

The hidden-buffer inputs are read during the copy cycles, so the receiver holds them stable until the copy completes.

Top module: `msgbuf_copy_ctrl`

## Requirements
- R1: A validation strobe seen while idle raises busy_o on the next clock edge. busy_o then stays high for exactly MIN_COPY_CYC (17) cycles, whatever the DLC of the frame.
- R2: During the first 10 busy cycles, mem_we_o writes the whole hidden buffer to the selected buffer at consecutive addresses. Address 0 holds the ID. Address 1 holds the control word, with RTR in bit 0 and DLC in bits 4:1. Address 2+k holds data byte k, taken from hid_data_i[8k+7:8k].
- R3: A buffer in ready (0010) reads 0011 while it is being filled and 0100 (full) afterwards. A buffer in not-active (0000) reads 0001 and then returns to 0000.
- R4: A buffer in full (0100) reads 0101 during the copy and 0110 (overrun) afterwards. A buffer already in overrun reads 0111 and then 0110.
- R5: While busy, cpu_mem_we_o stays low for a CPU data write whose cpu_idx_i equals the buffer being filled. CPU data writes to any other buffer, and all CPU data writes while idle, pass through.
- R6: A CPU status write to the buffer being filled is accepted and reads back with bit 0 set. When the copy completes it is translated: 0010 becomes 0100, 0000 stays 0000, and 0100 becomes 0110.
- R7: rx_done_o is high for exactly one cycle: the first cycle after busy_o falls. In that cycle rx_done_idx_o gives the filled buffer and the final status is already readable.
- R8: A validation strobe that arrives while busy is held. Its copy starts on the second edge after the running copy completes, so busy_o is low for exactly one cycle between the two copies.
- R9: After reset every status reads 0000, and busy_o, mem_we_o and rx_done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Frame validation strobe |
| sel_idx_i | input | IDX_W | Buffer chosen by the acceptance matcher |
| hid_id_i | input | ID_W | Hidden buffer identifier |
| hid_ctl_i | input | CTL_W | Hidden buffer control word {DLC, RTR} |
| hid_data_i | input | 8*DATA_BYTES | Hidden buffer data bytes, byte 0 in the low bits |
| mem_we_o | output | 1 | Copy write enable |
| mem_idx_o | output | IDX_W | Buffer being filled |
| mem_addr_o | output | ADDR_W | Word address within the buffer |
| mem_wdata_o | output | ID_W | Word written |
| cpu_we_i | input | 1 | CPU data write request |
| cpu_idx_i | input | IDX_W | Buffer addressed by a CPU write |
| cpu_mem_we_o | output | 1 | Gated CPU data write enable |
| cpu_st_we_i | input | 1 | CPU status write |
| cpu_st_i | input | 4 | Status value written by the CPU |
| st_rd_idx_i | input | IDX_W | Status read select |
| st_rd_o | output | 4 | Status of the selected buffer |
| busy_o | output | 1 | Copy in progress |
| rx_done_o | output | 1 | One-cycle copy completion pulse |
| rx_done_idx_o | output | IDX_W | Buffer index carried with rx_done_o |

## Verification
A copy counter that is off by one shows at once as a busy window of 16 or 18 cycles. It also shows as a missing or stray write at address 9. A wrong captured target index sends the words, the in-progress bit and the completion index to the wrong buffer, and the status port exposes this within the first busy cycle. A faulty translation table, or a lost CPU status write, shows in the status read in the same cycle as the completion pulse. A pending slot that fails to hold shows as a missing second busy window, or one whose start is shifted, on the second edge after the first completion.

// File: rtl/mbcc_pkg.sv
package mbcc_pkg;
  typedef logic [3:0] st_t;

  localparam st_t ST_OFF   = 4'b0000;
  localparam st_t ST_READY = 4'b0010;
  localparam st_t ST_FULL  = 4'b0100;
  localparam st_t ST_OVR   = 4'b0110;

  // status code applied when a copy completes; bit 0 (busy) is dropped
  function automatic st_t st_finish(st_t s);
    case (s[3:1])
      3'b000:         return ST_OFF;
      3'b001:         return ST_FULL;
      3'b010, 3'b011: return ST_OVR;
      default:        return {s[3:1], 1'b0};
    endcase
  endfunction
endpackage

// File: rtl/mbcc_seq.sv
module mbcc_seq #(
  parameter int MIN_COPY_CYC = 17,
  parameter int IDX_W        = 4,
  parameter int CNT_W        = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] sel_idx_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [IDX_W-1:0] cur_idx_o,
  output logic             start_o,
  output logic [IDX_W-1:0] start_idx_o,
  output logic             fin_o,
  output logic             done_o,
  output logic [IDX_W-1:0] done_idx_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_COPY_CYC - 1);

  logic             busy_q, pend_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] cur_q, pend_idx_q, done_idx_q;

  assign start_o     = !busy_q && (pend_q || valid_i);
  assign start_idx_o = pend_q ? pend_idx_q : sel_idx_i;
  assign fin_o       = busy_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      pend_q     <= 1'b0;
      done_q     <= 1'b0;
      cnt_q      <= '0;
      cur_q      <= '0;
      pend_idx_q <= '0;
      done_idx_q <= '0;
    end else begin
      done_q <= fin_o;
      if (fin_o) done_idx_q <= cur_q;

      if (start_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        cur_q  <= start_idx_o;
      end else if (fin_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end

      // single pending slot; a strobe arriving while idle with a slot full refills it
      if (valid_i && (busy_q || pend_q)) begin
        pend_q     <= 1'b1;
        pend_idx_q <= sel_idx_i;
      end else if (start_o) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign busy_o     = busy_q;
  assign cnt_o      = cnt_q;
  assign cur_idx_o  = cur_q;
  assign done_o     = done_q;
  assign done_idx_o = done_idx_q;
endmodule

// File: rtl/mbcc_status.sv
module mbcc_status
  import mbcc_pkg::*;
#(
  parameter int NUM_BUFS = 15,
  parameter int IDX_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic             fin_i,
  input  logic             busy_i,
  input  logic [IDX_W-1:0] cur_idx_i,
  input  logic             cpu_st_we_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  st_t              cpu_st_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output st_t              rd_st_o
);
  st_t st_q [NUM_BUFS];

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
    localparam logic [IDX_W-1:0] B_IDX = IDX_W'(b);
    logic cpu_hit, is_cur;
    st_t  base;

    assign cpu_hit = cpu_st_we_i && (cpu_idx_i == B_IDX);
    assign is_cur  = cur_idx_i == B_IDX;
    assign base    = cpu_hit ? cpu_st_i : st_q[b];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[b] <= ST_OFF;
      end else if (fin_i && is_cur) begin
        st_q[b] <= st_finish(base);
      end else if (start_i && (start_idx_i == B_IDX)) begin
        st_q[b] <= {base[3:1], 1'b1};
      end else if (cpu_hit) begin
        st_q[b] <= (busy_i && is_cur) ? {cpu_st_i[3:1], 1'b1} : cpu_st_i;
      end
    end
  end

  always_comb begin
    rd_st_o = ST_OFF;
    for (int b = 0; b < NUM_BUFS; b++) begin
      if (rd_idx_i == IDX_W'(b)) rd_st_o = st_q[b];
    end
  end
endmodule

// File: rtl/mbcc_word.sv
module mbcc_word #(
  parameter int ID_W       = 29,
  parameter int CTL_W      = 5,
  parameter int DATA_BYTES = 8,
  parameter int ADDR_W     = 4
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [ID_W-1:0]         id_i,
  input  logic [CTL_W-1:0]        ctl_i,
  input  logic [8*DATA_BYTES-1:0] data_i,
  output logic [ID_W-1:0]         word_o
);
  always_comb begin
    word_o = '0;
    if (addr_i == ADDR_W'(0)) begin
      word_o = id_i;
    end else if (addr_i == ADDR_W'(1)) begin
      word_o[CTL_W-1:0] = ctl_i;
    end else begin
      for (int k = 0; k < DATA_BYTES; k++) begin
        if (addr_i == ADDR_W'(k + 2)) word_o[7:0] = data_i[8*k +: 8];
      end
    end
  end
endmodule

// File: rtl/msgbuf_copy_ctrl.sv
module msgbuf_copy_ctrl
  import mbcc_pkg::*;
#(
  parameter int NUM_BUFS     = 15,
  parameter int ID_W         = 29,
  parameter int CTL_W        = 5,
  parameter int DATA_BYTES   = 8,
  parameter int MIN_COPY_CYC = 17,
  localparam int IDX_W       = $clog2(NUM_BUFS),
  localparam int NUM_WORDS   = DATA_BYTES + 2,
  localparam int ADDR_W      = $clog2(NUM_WORDS),
  localparam int CNT_W       = $clog2(MIN_COPY_CYC)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [IDX_W-1:0]        sel_idx_i,
  input  logic [ID_W-1:0]         hid_id_i,
  input  logic [CTL_W-1:0]        hid_ctl_i,
  input  logic [8*DATA_BYTES-1:0] hid_data_i,
  output logic                    mem_we_o,
  output logic [IDX_W-1:0]        mem_idx_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [ID_W-1:0]         mem_wdata_o,
  input  logic                    cpu_we_i,
  input  logic [IDX_W-1:0]        cpu_idx_i,
  output logic                    cpu_mem_we_o,
  input  logic                    cpu_st_we_i,
  input  logic [3:0]              cpu_st_i,
  input  logic [IDX_W-1:0]        st_rd_idx_i,
  output logic [3:0]              st_rd_o,
  output logic                    busy_o,
  output logic                    rx_done_o,
  output logic [IDX_W-1:0]        rx_done_idx_o
);
  logic             busy, start, fin;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] cur_idx, start_idx;

  mbcc_seq #(
    .MIN_COPY_CYC(MIN_COPY_CYC),
    .IDX_W       (IDX_W),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .sel_idx_i  (sel_idx_i),
    .busy_o     (busy),
    .cnt_o      (cnt),
    .cur_idx_o  (cur_idx),
    .start_o    (start),
    .start_idx_o(start_idx),
    .fin_o      (fin),
    .done_o     (rx_done_o),
    .done_idx_o (rx_done_idx_o)
  );

  mbcc_status #(
    .NUM_BUFS(NUM_BUFS),
    .IDX_W   (IDX_W)
  ) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .start_idx_i(start_idx),
    .fin_i      (fin),
    .busy_i     (busy),
    .cur_idx_i  (cur_idx),
    .cpu_st_we_i(cpu_st_we_i),
    .cpu_idx_i  (cpu_idx_i),
    .cpu_st_i   (cpu_st_i),
    .rd_idx_i   (st_rd_idx_i),
    .rd_st_o    (st_rd_o)
  );

  mbcc_word #(
    .ID_W      (ID_W),
    .CTL_W     (CTL_W),
    .DATA_BYTES(DATA_BYTES),
    .ADDR_W    (ADDR_W)
  ) u_word (
    .addr_i(mem_addr_o),
    .id_i  (hid_id_i),
    .ctl_i (hid_ctl_i),
    .data_i(hid_data_i),
    .word_o(mem_wdata_o)
  );

  assign mem_addr_o   = cnt[ADDR_W-1:0];
  assign mem_we_o     = busy && (cnt < CNT_W'(NUM_WORDS));
  assign mem_idx_o    = cur_idx;
  assign busy_o       = busy;
  assign cpu_mem_we_o = cpu_we_i && !(busy && (cpu_idx_i == cur_idx));
endmodule

// File: rtl/msgbuf_copy_chk.sv
module msgbuf_copy_chk #(
  parameter int MIN_COPY_CYC = 17,
  parameter int IDX_W        = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             mem_we_o,
  input logic [IDX_W-1:0] mem_idx_o,
  input logic             cpu_we_i,
  input logic [IDX_W-1:0] cpu_idx_i,
  input logic             cpu_mem_we_o,
  input logic             rx_done_o,
  input logic [IDX_W-1:0] st_rd_idx_i,
  input logic [3:0]       st_rd_o
);
  localparam int RUN_W = $clog2(MIN_COPY_CYC) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  AST_COPY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == RUN_W'(MIN_COPY_CYC)); // R1

  AST_WR_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o); // R2

  AST_TARGET_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mem_idx_o)); // R2

  AST_BUSY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (st_rd_idx_i == mem_idx_o) |-> st_rd_o[0]); // R3

  AST_CPU_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cpu_we_i && (cpu_idx_i == mem_idx_o) |-> !cpu_mem_we_o); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> !busy_o && $past(busy_o)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o); // R7
endmodule

bind msgbuf_copy_ctrl msgbuf_copy_chk #(
  .MIN_COPY_CYC(MIN_COPY_CYC),
  .IDX_W       (IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .mem_we_o    (mem_we_o),
  .mem_idx_o   (mem_idx_o),
  .cpu_we_i    (cpu_we_i),
  .cpu_idx_i   (cpu_idx_i),
  .cpu_mem_we_o(cpu_mem_we_o),
  .rx_done_o   (rx_done_o),
  .st_rd_idx_i (st_rd_idx_i),
  .st_rd_o     (st_rd_o)
);

// File: tb/msgbuf_copy_ctrl_tb.sv
`timescale 1ns/1ps
module msgbuf_copy_ctrl_tb;
  localparam int NB = 15;
  localparam int LEN = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  sel_idx = '0;
  logic [28:0] hid_id = '0;
  logic [4:0]  hid_ctl = '0;
  logic [63:0] hid_data = '0;
  logic        mem_we;
  logic [3:0]  mem_idx;
  logic [3:0]  mem_addr;
  logic [28:0] mem_wdata;
  logic        cpu_we = 1'b0;
  logic [3:0]  cpu_idx = '0;
  logic        cpu_mem_we;
  logic        cpu_st_we = 1'b0;
  logic [3:0]  cpu_st = '0;
  logic [3:0]  st_rd_idx = '0;
  logic [3:0]  st_rd;
  logic        busy;
  logic        rx_done;
  logic [3:0]  rx_done_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [28:0] bmem [NB][10];
  int wr_cnt = 0;

  always #4 clk = ~clk;

  msgbuf_copy_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sel_idx_i(sel_idx),
    .hid_id_i(hid_id), .hid_ctl_i(hid_ctl), .hid_data_i(hid_data),
    .mem_we_o(mem_we), .mem_idx_o(mem_idx), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .cpu_we_i(cpu_we), .cpu_idx_i(cpu_idx), .cpu_mem_we_o(cpu_mem_we),
    .cpu_st_we_i(cpu_st_we), .cpu_st_i(cpu_st), .st_rd_idx_i(st_rd_idx), .st_rd_o(st_rd),
    .busy_o(busy), .rx_done_o(rx_done), .rx_done_idx_o(rx_done_idx)
  );

  always @(negedge clk) begin
    if (mem_we) begin
      bmem[mem_idx][mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic set_hidden(input int seed, input logic [3:0] dlc);
    hid_id  = 29'h0ABC_D000 ^ 29'(seed * 32'h0001_3579);
    hid_ctl = {dlc, 1'(seed)};
    for (int k = 0; k < 8; k++) hid_data[8*k +: 8] = 8'(seed * 7 + k * 16 + 1);
  endtask

  task automatic set_st(input int idx, input logic [3:0] v);
    @(negedge clk);
    cpu_st_we = 1'b1; cpu_idx = 4'(idx); cpu_st = v;
    @(negedge clk);
    cpu_st_we = 1'b0;
    st_rd_idx = 4'(idx);
    #1 chk(st_rd == v, "R6 idle status write", 32'(st_rd), 32'(v));
  endtask

  task automatic check_words(input int idx);
    chk(bmem[idx][0] == hid_id, "R2 id word", 32'(bmem[idx][0]), 32'(hid_id));
    chk(bmem[idx][1] == 29'(hid_ctl), "R2 ctl word", 32'(bmem[idx][1]), 32'(hid_ctl));
    for (int k = 0; k < 8; k++)
      chk(bmem[idx][2+k] == 29'(hid_data[8*k +: 8]), "R2 data byte",
          32'(bmem[idx][2+k]), 32'(hid_data[8*k +: 8]));
  endtask

  // one copy; optional CPU status write to the target in busy cycle 8
  task automatic run_copy(input int idx, input int seed, input logic [3:0] dlc,
                          input logic [3:0] exp_busy, input logic [3:0] exp_fin,
                          input string req, input bit mid_en, input logic [3:0] mid_st);
    logic [3:0] exp_now;
    int busy_n;
    int wr0;
    exp_now = exp_busy;
    busy_n = 0;
    @(negedge clk);
    set_hidden(seed, dlc);
    valid = 1'b1; sel_idx = 4'(idx); st_rd_idx = 4'(idx);
    wr0 = wr_cnt;
    @(negedge clk);
    valid = 1'b0;
    for (int k = 1; k <= LEN; k++) begin
      #1;
      if (busy) busy_n++;
      chk(st_rd == exp_now, req, 32'(st_rd), 32'(exp_now));
      chk(!rx_done, "R7 no early done", 32'(rx_done), 0);
      if (mid_en && k == 8) begin
        cpu_st_we = 1'b1; cpu_idx = 4'(idx); cpu_st = mid_st;
        exp_now = {mid_st[3:1], 1'b1};
      end else begin
        cpu_st_we = 1'b0;
      end
      @(negedge clk);
    end
    cpu_st_we = 1'b0;
    #1;
    chk(busy_n == LEN, "R1 busy length", 32'(busy_n), LEN);
    chk(!busy, "R1 busy falls", 32'(busy), 0);
    chk(rx_done && rx_done_idx == 4'(idx), "R7 done pulse/index",
        {27'(rx_done), rx_done_idx}, {27'(1), 4'(idx)});
    chk(st_rd == exp_fin, req, 32'(st_rd), 32'(exp_fin));
    chk(wr_cnt - wr0 == 10, "R2 write count", 32'(wr_cnt - wr0), 10);
    check_words(idx);
    @(negedge clk);
    #1 chk(!rx_done, "R7 single cycle", 32'(rx_done), 0);
  endtask

  task automatic t_reset;
    #1;
    chk(!busy && !mem_we && !rx_done, "R9 outputs idle", {29'(0), busy, mem_we, rx_done}, 0);
    for (int b = 0; b < NB; b++) begin
      st_rd_idx = 4'(b);
      #1 chk(st_rd == 4'b0000, "R9 status reset", 32'(st_rd), 0);
    end
  endtask

  task automatic t_ready_full_overrun;
    set_st(3, 4'b0010);
    run_copy(3, 11, 4'd8, 4'b0011, 4'b0100, "R3 ready to full", 1'b0, 4'b0);
    run_copy(3, 12, 4'd0, 4'b0101, 4'b0110, "R4 full to overrun", 1'b0, 4'b0);
    run_copy(3, 13, 4'd3, 4'b0111, 4'b0110, "R4 overrun stays", 1'b0, 4'b0);
  endtask

  task automatic t_not_active;
    run_copy(9, 21, 4'd5, 4'b0001, 4'b0000, "R3 not-active stays", 1'b0, 4'b0);
  endtask

  task automatic t_cpu_status;
    set_st(5, 4'b0100);
    run_copy(5, 31, 4'd2, 4'b0101, 4'b0100, "R6 ready written in busy", 1'b1, 4'b0010);
    set_st(6, 4'b0010);
    run_copy(6, 32, 4'd8, 4'b0011, 4'b0000, "R6 off written in busy", 1'b1, 4'b0000);
    set_st(7, 4'b0010);
    run_copy(7, 33, 4'd1, 4'b0011, 4'b0110, "R6 full written in busy", 1'b1, 4'b0100);
  endtask

  task automatic t_cpu_block;
    @(negedge clk);
    cpu_we = 1'b1; cpu_idx = 4'd5;
    #1 chk(cpu_mem_we, "R5 idle write passes", 32'(cpu_mem_we), 1);
    cpu_we = 1'b0;
    set_hidden(41, 4'd8);
    valid = 1'b1; sel_idx = 4'd5;
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);
    cpu_we = 1'b1; cpu_idx = 4'd5;
    #1 chk(!cpu_mem_we, "R5 write to target blocked", 32'(cpu_mem_we), 0);
    cpu_idx = 4'd6;
    #1 chk(cpu_mem_we, "R5 write to other passes", 32'(cpu_mem_we), 1);
    cpu_we = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_pending;
    int low_n;
    set_st(1, 4'b0010);
    set_st(2, 4'b0010);
    @(negedge clk);
    set_hidden(51, 4'd8);
    valid = 1'b1; sel_idx = 4'd1;
    @(negedge clk);
    valid = 1'b0;
    repeat (4) @(negedge clk);
    valid = 1'b1; sel_idx = 4'd2;
    @(negedge clk);
    valid = 1'b0;
    // now at N6; first copy completes before N18
    repeat (12) @(negedge clk);
    #1 chk(!busy && rx_done && rx_done_idx == 4'd1, "R8 first copy done",
           {26'(0), busy, rx_done, rx_done_idx}, {26'(0), 2'b01, 4'd1});
    @(negedge clk);
    #1 chk(busy, "R8 held copy starts", 32'(busy), 1);
    st_rd_idx = 4'd2;
    #1 chk(st_rd == 4'b0011, "R8 held copy target", 32'(st_rd), 32'(4'b0011));
    low_n = 0;
    while (busy) begin @(negedge clk); low_n++; end
    #1 chk(low_n == LEN && rx_done && rx_done_idx == 4'd2, "R8 held copy done",
           {24'(low_n), rx_done_idx}, {24'(LEN), 4'd2});
    chk(st_rd == 4'b0100, "R8 held copy status", 32'(st_rd), 32'(4'b0100));
    check_words(2);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_ready_full_overrun();
    t_not_active();
    t_cpu_status();
    t_cpu_block();
    t_pending();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule